// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block gathers the interrupt requests of a small 8-bit processor core and decides, once per instruction, which one the core should service next. Five sources are handled: one non-maskable line, three maskable lines that each branch to a fixed 16-bit address, and one maskable external line that has no fixed address. For the external line the block runs an acknowledge cycle and captures a restart opcode that the requesting device drives onto the 8-bit data bus.

The core pulses `insn_done_i` at the end of each instruction. Arbitration happens only in that cycle. Software controls a global enable with separate set and clear pulses, and sets a mask bit per vectored line through a small write port. Every accepted interrupt clears the global enable, so the service routine must enable interrupts again when it is ready to nest. Results appear as a one-cycle `vec_valid_o` pulse that carries an address and a 3-bit source ID. For the external line the address field holds the captured opcode, zero-extended.

The control sequencer has two states. IDLE is the reset state. It arbitrates on the instruction strobe. Acceptance of a fixed-address source issues the vector directly and stays in IDLE. Acceptance of the external line moves to BUS_ACK, with the acknowledge asserted. BUS_ACK always returns to IDLE after one cycle. In that cycle it samples the bus and issues the external result.

Top module: `irq_vector_ctl`

## Requirements
- R1: The non-maskable line (source ID 0) is accepted at an instruction boundary regardless of the global enable and the mask bits, and yields address 0x0024.
- R2: Reset clears the global enable. A pulse on `ien_clr_i` also clears it. While the enable is clear, no maskable source (IDs 1 to 4) produces a result. A pulse on `ien_set_i` sets the enable.
- R3: Accepting any source clears the global enable. A maskable request that is still pending is not accepted until a new `ien_set_i` pulse.
- R4: When the external line (ID 4) wins, `ack_o` is high for exactly the cycle after the boundary edge. `bus_data_i` is sampled at the end of that cycle. On the next cycle `vec_valid_o` pulses with ID 4 and `vec_addr_o` = {8'h00, opcode}.
- R5: Fixed priority from highest to lowest is ID 0 (non-maskable), ID 1 (top level), ID 2 (middle level), ID 3 (low level), ID 4 (external).
- R6: A mask write (`mask_we_i`) loads the mask bits: `mask_wdata_i[2]` masks ID 1, bit 1 masks ID 2 and bit 0 masks ID 3, where 1 means masked. Reset sets all three mask bits. A masked line never produces a result.
- R7: Requests are examined only in a cycle with `insn_done_i` high. A pending request causes no result while the strobe stays low.
- R8: A rising edge on ID 1's line is latched even when the line is masked or the enable is clear. The latch is held after the line falls, cleared when ID 1 is accepted, and cleared by a mask write with `mask_wdata_i[3]` = 1.
- R9: IDs 2 and 3 are level-sensitive. A request that drops before the boundary produces nothing.
- R10: For a fixed-address source, `vec_valid_o` is high for the single cycle after the boundary edge. IDs 1, 2 and 3 give addresses 0x003C, 0x0034 and 0x002C. After reset, `vec_valid_o` and `ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_nmi_i | input | 1 | Non-maskable request, level |
| irq_lvl_i | input | 3 | Vectored requests: bit 2 edge (ID 1), bit 1 level (ID 2), bit 0 level (ID 3) |
| irq_ext_i | input | 1 | External non-vectored request, level |
| insn_done_i | input | 1 | Instruction boundary strobe from the core |
| ien_set_i | input | 1 | Global enable set pulse |
| ien_clr_i | input | 1 | Global enable clear pulse |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 4 | Bits 2..0 mask bits, bit 3 clears the edge latch |
| bus_data_i | input | 8 | Data bus carrying the restart opcode |
| ack_o | output | 1 | Acknowledge for the external line |
| vec_valid_o | output | 1 | One-cycle result strobe |
| vec_addr_o | output | 16 | Vector address, or zero-extended opcode for ID 4 |
| vec_src_o | output | 3 | Source ID of the result |

## Verification
The hardest situation to reach is a request stack where all five lines are raised together and each must be granted in turn. This only works if the global enable is pulsed again between grants and the edge latch survives while lower levels are served. The stimulus raises all five lines, then walks through five enable-and-boundary rounds, dropping each line after its grant. A second hard case is a top-level pulse that arrives while the line is masked. The stimulus shows the latch persists once the mask is lifted, and then shows that a mask write with the clear bit removes it.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int SRC_W   = 3;
    localparam int N_SRC   = 5;
    localparam int N_LVL   = 3;
    localparam int ADDR_W  = 16;

    localparam logic [SRC_W-1:0] SRC_NMI = 3'd0;
    localparam logic [SRC_W-1:0] SRC_TOP = 3'd1;
    localparam logic [SRC_W-1:0] SRC_MID = 3'd2;
    localparam logic [SRC_W-1:0] SRC_LOW = 3'd3;
    localparam logic [SRC_W-1:0] SRC_EXT = 3'd4;

    localparam logic [ADDR_W-1:0] NMI_ADDR  = 16'h0024;
    localparam logic [ADDR_W-1:0] LVL_BASE  = 16'h0044;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_BUS_ACK = 1'b1
    } ctl_state_t;

    // Level sources step down by eight bytes per priority rank.
    function automatic logic [ADDR_W-1:0] src_vector(input logic [SRC_W-1:0] idx);
        logic [ADDR_W-1:0] off;
        off = {{(ADDR_W-SRC_W-3){1'b0}}, idx, 3'b000};
        if (idx == SRC_NMI) return NMI_ADDR;
        return LVL_BASE - off;
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = req_i && !prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= req_i;
            if (rise)
                pend_q <= 1'b1;
            else if (clr_i)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R8: an edge is always captured
    a_r8_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !prev_q) |=> pend_q);

    // R8: a latched request stays until cleared
    a_r8_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_i) |=> pend_q);

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic [NS-1:0]    elig_i,
    output logic             win_valid_o,
    output logic [SRC_W-1:0] win_idx_o
);
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                win_valid_o = 1'b1;
                win_idx_o   = SRC_W'(i);
            end
        end
    end

    // R5: the lowest-numbered eligible source wins
    always_comb begin
        if (win_valid_o)
            a_r5_lowest_wins: assert (elig_i[win_idx_o]);
    end

endmodule

// File: rtl/irq_seq_ctl.sv
module irq_seq_ctl
    import irq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done_i,
    input  logic              ien_set_i,
    input  logic              ien_clr_i,
    input  logic              nmi_req_i,
    input  logic              win_valid_i,
    input  logic [SRC_W-1:0]  win_idx_i,
    input  logic [DW-1:0]     bus_data_i,
    output logic              ien_o,
    output logic              take_o,
    output logic              ack_o,
    output logic              vec_valid_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic [SRC_W-1:0]  vec_src_o
);
    ctl_state_t st_q, st_d;
    logic ien_q;
    logic take;

    assign take   = (st_q == ST_IDLE) && insn_done_i && win_valid_i;
    assign take_o = take;
    assign ien_o  = ien_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (take && win_idx_i == SRC_EXT) st_d = ST_BUS_ACK;
            ST_BUS_ACK: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 ien_q <= 1'b0;
        else if (take || ien_clr_i) ien_q <= 1'b0;
        else if (ien_set_i)         ien_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o       <= 1'b0;
            vec_valid_o <= 1'b0;
            vec_addr_o  <= '0;
            vec_src_o   <= '0;
        end else begin
            ack_o       <= 1'b0;
            vec_valid_o <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (take) begin
                        if (win_idx_i == SRC_EXT) begin
                            ack_o <= 1'b1;
                        end else begin
                            vec_valid_o <= 1'b1;
                            vec_addr_o  <= src_vector(win_idx_i);
                            vec_src_o   <= win_idx_i;
                        end
                    end
                end
                ST_BUS_ACK: begin
                    vec_valid_o <= 1'b1;
                    vec_addr_o  <= {{(ADDR_W-DW){1'b0}}, bus_data_i};
                    vec_src_o   <= SRC_EXT;
                end
                default: ;
            endcase
        end
    end

    // R1: a non-maskable request at a boundary is granted next cycle
    a_r1_nmi_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && insn_done_i && nmi_req_i) |=> (vec_valid_o && vec_src_o == SRC_NMI));

    // R3: every grant leaves the global enable clear
    a_r3_grant_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ien_q);

    // R2: fixed-address maskable grants need the enable
    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && vec_src_o != SRC_NMI && vec_src_o != SRC_EXT) |-> $past(ien_q));

    // R4: acknowledge is one cycle and is followed by the external result
    a_r4_ack_then_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> (!ack_o && vec_valid_o && vec_src_o == SRC_EXT));

endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_nmi_i,
    input  logic [2:0]        irq_lvl_i,
    input  logic              irq_ext_i,
    input  logic              insn_done_i,
    input  logic              ien_set_i,
    input  logic              ien_clr_i,
    input  logic              mask_we_i,
    input  logic [3:0]        mask_wdata_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              ack_o,
    output logic              vec_valid_o,
    output logic [15:0]       vec_addr_o,
    output logic [2:0]        vec_src_o
);
    localparam int CLR_BIT = N_LVL;

    logic [N_LVL-1:0] mask_q;
    logic [N_SRC-1:0] elig;
    logic             pend_top;
    logic             ien;
    logic             take;
    logic             win_valid;
    logic [SRC_W-1:0] win_idx;
    logic             top_clr;

    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_we_i) mask_q <= mask_wdata_i[N_LVL-1:0];
    end

    assign top_clr = (take && win_idx == SRC_TOP) || (mask_we_i && mask_wdata_i[CLR_BIT]);

    irq_edge_latch u_top_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_lvl_i[N_LVL-1]),
        .clr_i  (top_clr),
        .pend_o (pend_top)
    );

    // Eligibility: index 0 is the non-maskable line, 1..N_LVL are level lines
    // from top to low, the last index is the external line.
    assign elig[0] = irq_nmi_i;
    generate
        for (genvar k = 1; k <= N_LVL; k++) begin : g_lvl
            if (k == 1) begin : g_edge
                assign elig[k] = ien && !mask_q[N_LVL-k] && pend_top;
            end else begin : g_level
                assign elig[k] = ien && !mask_q[N_LVL-k] && irq_lvl_i[N_LVL-k];
            end
        end
    endgenerate
    assign elig[N_SRC-1] = ien && irq_ext_i;

    irq_prio_arb #(.NS(N_SRC)) u_arb (
        .elig_i      (elig),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx)
    );

    irq_seq_ctl #(.DW(DATA_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_done_i (insn_done_i),
        .ien_set_i   (ien_set_i),
        .ien_clr_i   (ien_clr_i),
        .nmi_req_i   (irq_nmi_i),
        .win_valid_i (win_valid),
        .win_idx_i   (win_idx),
        .bus_data_i  (bus_data_i),
        .ien_o       (ien),
        .take_o      (take),
        .ack_o       (ack_o),
        .vec_valid_o (vec_valid_o),
        .vec_addr_o  (vec_addr_o),
        .vec_src_o   (vec_src_o)
    );

    // R6: a masked middle line never yields a result
    a_r6_mid_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && vec_src_o == SRC_MID) |-> !$past(mask_q[1]));

    // R7: a grant only follows a boundary strobe
    a_r7_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && vec_src_o != SRC_EXT) |-> $past(insn_done_i));

endmodule

// File: tb/irq_vector_ctl_bench.sv
module irq_vector_ctl_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_nmi = 1'b0;
    logic [2:0]  irq_lvl = 3'b000;
    logic        irq_ext = 1'b0;
    logic        insn_done = 1'b0;
    logic        ien_set = 1'b0;
    logic        ien_clr = 1'b0;
    logic        mask_we = 1'b0;
    logic [3:0]  mask_wdata = 4'h0;
    logic [7:0]  bus_data = 8'hFF;
    logic        ack;
    logic        vec_valid;
    logic [15:0] vec_addr;
    logic [2:0]  vec_src;

    int n_checks = 0;
    int n_fail   = 0;
    int n_stray  = 0;
    bit done     = 1'b0;

    logic [18:0] exp_q[$];
    string       tag_q[$];

    always #(PERIOD/2) clk = ~clk;

    irq_vector_ctl u_irq_vector_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_nmi_i    (irq_nmi),
        .irq_lvl_i    (irq_lvl),
        .irq_ext_i    (irq_ext),
        .insn_done_i  (insn_done),
        .ien_set_i    (ien_set),
        .ien_clr_i    (ien_clr),
        .mask_we_i    (mask_we),
        .mask_wdata_i (mask_wdata),
        .bus_data_i   (bus_data),
        .ack_o        (ack),
        .vec_valid_o  (vec_valid),
        .vec_addr_o   (vec_addr),
        .vec_src_o    (vec_src)
    );

    // Monitor: pops expected results as the design emits them.
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                n_stray++;
                $display("FAIL unexpected result: got src=%0d addr=%h, expected none", vec_src, vec_addr);
            end else begin
                logic [18:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({vec_src, vec_addr} !== e) begin
                    n_fail++;
                    $display("FAIL %s: got src=%0d addr=%h, expected src=%0d addr=%h",
                             t, vec_src, vec_addr, e[18:16], e[15:0]);
                end
            end
        end
    end

    task automatic expect_vec(input logic [2:0] s, input logic [15:0] a, input string t);
        exp_q.push_back({s, a});
        tag_q.push_back(t);
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic boundary();
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
    endtask

    task automatic enable();
        ien_set = 1'b1;
        @(negedge clk);
        ien_set = 1'b0;
    endtask

    task automatic write_mask(input logic [3:0] v);
        mask_we = 1'b1;
        mask_wdata = v;
        @(negedge clk);
        mask_we = 1'b0;
        mask_wdata = 4'h0;
    endtask

    task automatic expect_none(input string t);
        int snap;
        snap = n_stray;
        cycles(3);
        n_checks++;
        if (n_stray != snap)
            $display("  (%s: result seen where none expected)", t);
    endtask

    // External acknowledge flow: boundary, check ack, drive bus.
    task automatic ext_grant(input logic [7:0] op, input string t);
        expect_vec(3'd4, {8'h00, op}, t);
        boundary();
        n_checks++;
        if (ack !== 1'b1) begin
            n_fail++;
            $display("FAIL R4 ack: got %b, expected 1", ack);
        end
        bus_data = op;
        @(negedge clk);
        bus_data = 8'hFF;
        n_checks++;
        if (ack !== 1'b0) begin
            n_fail++;
            $display("FAIL R4 ack width: got %b, expected 0", ack);
        end
        cycles(1);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R10 reset outputs
        n_checks++;
        if (vec_valid !== 1'b0 || ack !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset: got valid=%b ack=%b, expected 0 0", vec_valid, ack);
        end

        // R2: enable clear after reset, middle line unmasked
        write_mask(4'b0000);
        irq_lvl[1] = 1'b1;
        boundary();
        expect_none("R2 disabled after reset");
        irq_lvl[1] = 1'b0;

        // R1: non-maskable with enable clear and all masked
        write_mask(4'b0111);
        irq_nmi = 1'b1;
        expect_vec(3'd0, 16'h0024, "R1 nmi");
        boundary();
        irq_nmi = 1'b0;
        cycles(2);

        // R10: each fixed-address level
        write_mask(4'b0000);
        enable();
        irq_lvl[0] = 1'b1;
        expect_vec(3'd3, 16'h002C, "R10 low");
        boundary();
        irq_lvl[0] = 1'b0;
        cycles(2);
        enable();
        irq_lvl[1] = 1'b1;
        expect_vec(3'd2, 16'h0034, "R10 mid");
        boundary();
        irq_lvl[1] = 1'b0;
        cycles(2);
        // R8: short pulse on top line, then boundary later
        enable();
        irq_lvl[2] = 1'b1;
        cycles(1);
        irq_lvl[2] = 1'b0;
        cycles(2);
        expect_vec(3'd1, 16'h003C, "R8 latched pulse");
        boundary();
        cycles(2);
        enable();
        boundary();
        expect_none("R8 latch cleared on grant");

        // R3: grant clears enable, pending request waits
        ien_clr = 1'b1;
        cycles(1);
        ien_clr = 1'b0;
        enable();
        irq_lvl[1] = 1'b1;
        expect_vec(3'd2, 16'h0034, "R3 first");
        boundary();
        cycles(1);
        boundary();
        expect_none("R3 no regrant without enable");
        enable();
        expect_vec(3'd2, 16'h0034, "R3 after enable");
        boundary();
        cycles(2);

        // R7: no strobe, no result
        enable();
        cycles(5);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R7 queue: got %0d, expected 0", exp_q.size());
        end
        expect_none("R7 no strobe");
        expect_vec(3'd2, 16'h0034, "R7 strobe");
        boundary();
        irq_lvl[1] = 1'b0;
        cycles(2);

        // R5: all five raised, served in priority order
        irq_nmi = 1'b1;
        irq_lvl = 3'b111;
        irq_ext = 1'b1;
        enable();
        expect_vec(3'd0, 16'h0024, "R5 nmi first");
        boundary();
        irq_nmi = 1'b0;
        cycles(1);
        enable();
        expect_vec(3'd1, 16'h003C, "R5 top second");
        boundary();
        cycles(1);
        enable();
        expect_vec(3'd2, 16'h0034, "R5 mid third");
        boundary();
        irq_lvl[1] = 1'b0;
        cycles(1);
        enable();
        expect_vec(3'd3, 16'h002C, "R5 low fourth");
        boundary();
        irq_lvl[0] = 1'b0;
        cycles(1);
        enable();
        ext_grant(8'hD7, "R5 ext last");
        irq_ext = 1'b0;
        irq_lvl[2] = 1'b0;
        cycles(2);

        // R6: mid masked, low wins; then mid alone gives nothing
        write_mask(4'b0010);
        enable();
        irq_lvl[1] = 1'b1;
        irq_lvl[0] = 1'b1;
        expect_vec(3'd3, 16'h002C, "R6 low over masked mid");
        boundary();
        irq_lvl[0] = 1'b0;
        cycles(1);
        enable();
        boundary();
        expect_none("R6 masked mid");
        irq_lvl[1] = 1'b0;
        ien_clr = 1'b1;
        cycles(1);
        ien_clr = 1'b0;

        // R9: level line dropped before boundary
        write_mask(4'b0000);
        enable();
        irq_lvl[0] = 1'b1;
        cycles(1);
        irq_lvl[0] = 1'b0;
        boundary();
        expect_none("R9 dropped level");
        ien_clr = 1'b1;
        cycles(1);
        ien_clr = 1'b0;

        // R8: latch while masked survives unmask
        write_mask(4'b0100);
        irq_lvl[2] = 1'b1;
        cycles(1);
        irq_lvl[2] = 1'b0;
        write_mask(4'b0000);
        enable();
        expect_vec(3'd1, 16'h003C, "R8 latched while masked");
        boundary();
        cycles(2);
        // R8: mask write with clear bit drops latch
        irq_lvl[2] = 1'b1;
        cycles(1);
        irq_lvl[2] = 1'b0;
        write_mask(4'b1000);
        enable();
        boundary();
        expect_none("R8 cleared by mask write");
        ien_clr = 1'b1;
        cycles(1);
        ien_clr = 1'b0;

        // R4: external with another opcode
        enable();
        irq_ext = 1'b1;
        ext_grant(8'h3A, "R4 ext opcode");
        irq_ext = 1'b0;
        cycles(2);

        // R2: clear pulse disables
        enable();
        ien_clr = 1'b1;
        cycles(1);
        ien_clr = 1'b0;
        irq_lvl[0] = 1'b1;
        boundary();
        expect_none("R2 disabled by clear pulse");
        irq_lvl[0] = 1'b0;
        cycles(2);

        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 outstanding: got %0d, expected 0", exp_q.size());
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule